// File: doc/BRIEF.md
# Event Timestamping Engine

This block watches a wide bank of input lines, organised in groups of 32 called slices, and turns level changes into timestamped records. Each input is brought into the clock domain through a two-stage synchroniser. The synchronised value of every slice is then compared with its value one cycle earlier, but only on lines whose per-slice enable bit is set. When a slice shows a change, the block writes a record into an event queue. The record holds the current 64-bit timestamp, the slice number, and the slice's 32-bit value before and after the change. A reader finds the lines that moved by XOR-ing the two value words.

Software sees the block through a flat register bus with a single-cycle write strobe and a combinational read. It reads the head record word by word, then writes a pop command to move to the next record. A free-running 64-bit counter advances once per `tick_en` pulse and provides the timestamp. The interrupt output stays high while the queue holds at least a programmed number of records.

Top module: `evtstamp_engine`

## Requirements
- R1: After reset, the control word (0x00), the status word (0x20) and `irq` all read 0, and the queue holds no records.
- R2: A level change on an enabled input line, with global enable (control bit 0) set, places exactly one record in the queue. The record becomes visible no later than three clock edges after the input changes.
- R3: In a record, the source word (0x0C) carries the slice number in bits [23:16]. The before-value word (0x14) and after-value word (0x10) differ exactly in the enabled lines of that slice that changed. Disabled lines that toggle at the same time do not appear in the difference.
- R4: The timestamp counter is 64 bits wide and advances by one on each cycle where `tick_en` is high. A record stores the counter value of the cycle in which its change was detected, readable as the upper word (0x04) and the lower word (0x08).
- R5: When several slices change in the same cycle, one record per slice is queued in ascending slice order, and all of these records carry the same timestamp.
- R6: Writing a 1 to bit 0 of the command word (0x1C) removes the head record, so the next record appears in the read words. A pop while the queue is empty changes nothing. While the queue is empty, the record words read 0.
- R7: A record that arrives while the queue has no free slot is dropped, and sticky bit 0 of the status word is set. The bit stays set until bit 1 of the command word is written with 1. A pop in the same cycle does not free a slot for an arriving record.
- R8: `irq` is high exactly while interrupt enable (control bit 1) is set and the record count is at or above the threshold in control bits [15:8].
- R9: Slice N's enable mask sits at 0x40 + N*0x20, one bit per line, and reads back as written. No record is created while global enable is clear, or for a line whose mask bit is clear.
- R10: The status word reports the number of queued records in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timestamp advance strobe |
| lines_in | input | NUM_SLICES*32 | Asynchronous monitored lines; line index = slice*32 + bit |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq | output | 1 | Occupancy interrupt |

## Verification
A bad record count would show directly in the status word and on `irq` on the next read. It would also show as a record that does not match the expected one, or appears out of order, when the queue is drained. A wrong before/after snapshot or a wrong enable mask would appear in the XOR of the two value words on the first record that follows the faulty change. An error in the timestamp counter would appear as a wrong timestamp in the first record after the bad tick. A lost or stuck overflow flag would be visible in the status word as soon as the queue fills, or right after the clear command is written.

// File: rtl/evtstamp_engine.sv
module evtstamp_engine #(
  parameter int NUM_SLICES = 3,
  parameter int LOG2_DEPTH = 3,
  parameter int ADDR_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic [NUM_SLICES*32-1:0] lines_in,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     irq
);
  localparam int DEPTH = 1 << LOG2_DEPTH;
  localparam int CNT_W = LOG2_DEPTH + 1;
  localparam int LW    = NUM_SLICES * 32;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(32'h00);
  localparam logic [ADDR_W-1:0] A_TSHI = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] A_TSLO = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(32'h0C);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] A_PRV  = ADDR_W'(32'h14);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(32'h1C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(32'h20);

  logic [LW-1:0] sync1, sync2, last;
  logic          gen_en, int_en, ovf;
  logic [7:0]    thr;
  logic [31:0]   slice_en [NUM_SLICES];
  logic [63:0]   ts;

  logic [63:0]   ts_mem [DEPTH];
  logic [7:0]    sl_mem [DEPTH];
  logic [31:0]   pv_mem [DEPTH];
  logic [31:0]   cv_mem [DEPTH];
  logic [LOG2_DEPTH-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]      count;

  logic [31:0]           delta [NUM_SLICES];
  logic [NUM_SLICES-1:0] hit;
  int rank [NUM_SLICES];
  int n_hit, free_sl, n_acc;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_det
    assign delta[s] = (sync2[s*32 +: 32] ^ last[s*32 +: 32]) & slice_en[s];
    assign hit[s]   = gen_en && (delta[s] != 32'd0);
  end

  always_comb begin
    n_hit = 0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      rank[s] = n_hit;
      if (hit[s]) n_hit = n_hit + 1;
    end
    free_sl = DEPTH - int'(count);
    n_acc   = (n_hit < free_sl) ? n_hit : free_sl;
  end

  wire cmd_wr  = bus_we && (bus_addr == A_CMD);
  wire pop_ok  = cmd_wr && bus_wdata[0] && (count != '0);
  wire ovf_clr = cmd_wr && bus_wdata[1];
  wire has     = (count != '0);

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (hit[s] && rank[s] < free_sl) begin
        ts_mem[wr_ptr + LOG2_DEPTH'(rank[s])] <= ts;
        sl_mem[wr_ptr + LOG2_DEPTH'(rank[s])] <= 8'(s);
        pv_mem[wr_ptr + LOG2_DEPTH'(rank[s])] <= last[s*32 +: 32];
        cv_mem[wr_ptr + LOG2_DEPTH'(rank[s])] <= last[s*32 +: 32] ^ delta[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; last <= '0;
      gen_en <= 1'b0; int_en <= 1'b0; thr <= '0; ovf <= 1'b0;
      ts <= '0; wr_ptr <= '0; rd_ptr <= '0; count <= '0;
      for (int s = 0; s < NUM_SLICES; s++) slice_en[s] <= '0;
    end else begin
      sync1 <= lines_in;
      sync2 <= sync1;
      last  <= sync2;
      if (tick_en) ts <= ts + 64'd1;
      if (bus_we && bus_addr == A_CTRL) begin
        gen_en <= bus_wdata[0];
        int_en <= bus_wdata[1];
        thr    <= bus_wdata[15:8];
      end
      for (int s = 0; s < NUM_SLICES; s++)
        if (bus_we && bus_addr == ADDR_W'(64 + 32*s)) slice_en[s] <= bus_wdata;
      wr_ptr <= wr_ptr + LOG2_DEPTH'(n_acc);
      rd_ptr <= rd_ptr + LOG2_DEPTH'(pop_ok);
      count  <= count + CNT_W'(n_acc) - CNT_W'(pop_ok);
      if (n_hit > free_sl) ovf <= 1'b1;
      else if (ovf_clr)    ovf <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {16'd0, thr, 6'd0, int_en, gen_en};
      A_TSHI: bus_rdata = has ? ts_mem[rd_ptr][63:32] : '0;
      A_TSLO: bus_rdata = has ? ts_mem[rd_ptr][31:0] : '0;
      A_SRC:  bus_rdata = has ? {8'd0, sl_mem[rd_ptr], 16'd0} : '0;
      A_CUR:  bus_rdata = has ? cv_mem[rd_ptr] : '0;
      A_PRV:  bus_rdata = has ? pv_mem[rd_ptr] : '0;
      A_STAT: bus_rdata = {16'd0, 8'(count), 7'd0, ovf};
      default: bus_rdata = '0;
    endcase
    for (int s = 0; s < NUM_SLICES; s++)
      if (bus_addr == ADDR_W'(64 + 32*s)) bus_rdata = slice_en[s];
  end

  assign irq = int_en && (int'(count) >= int'(thr));

  // R4
  ts_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> ts == $past(ts) + 64'd1);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && n_hit == 0) |=> count == '0);
  // R6
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && n_hit == 0) |=> count == $past(count) - CNT_W'(1));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R3
  entry_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has |-> (pv_mem[rd_ptr] ^ cv_mem[rd_ptr]) != 32'd0);
  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> count <= $past(count));
endmodule

// File: tb/evtstamp_engine_test.sv
module evtstamp_engine_test;
  localparam int NS = 3;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic [63:0] ts;
    logic [7:0]  sl;
    logic [31:0] pv;
    logic [31:0] cv;
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_we = 1'b0;
  logic [NS*32-1:0] lines = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;

  int n_run = 0, n_fail = 0;
  logic [63:0] tsm = '0;
  logic gen_on = 1'b0;
  logic [31:0] en_m [NS];
  ent_t q[$];

  always #5 clk = ~clk;

  evtstamp_engine uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .lines_in(lines),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    tsm += 64'(n);
  endtask

  // driver: applies a line change and predicts the records it produces
  task automatic toggle(input logic [NS*32-1:0] mask);
    logic [NS*32-1:0] old;
    old = lines;
    @(negedge clk);
    lines = lines ^ mask;
    for (int s = 0; s < NS; s++) begin
      logic [31:0] d;
      d = mask[s*32 +: 32] & en_m[s];
      if (gen_on && d != 0 && q.size() < DEPTH)
        q.push_back('{tsm, 8'(s), old[s*32 +: 32], old[s*32 +: 32] ^ d});
    end
    repeat (5) @(negedge clk);
  endtask

  // monitor: drains the queue through the bus and compares with predictions
  task automatic drain(input string tag);
    logic [31:0] r;
    ent_t e;
    bread(12'h20, r);
    chk({tag, " R10 count"}, 64'(r[15:8]), 64'(q.size()));
    while (q.size() > 0) begin
      e = q.pop_front();
      bread(12'h04, r); chk({tag, " R4 ts_hi"}, 64'(r), 64'(e.ts[63:32]));
      bread(12'h08, r); chk({tag, " R4 ts_lo"}, 64'(r), 64'(e.ts[31:0]));
      bread(12'h0C, r); chk({tag, " R3 src"}, 64'(r), 64'({8'd0, e.sl, 16'd0}));
      bread(12'h14, r); chk({tag, " R3 prev"}, 64'(r), 64'(e.pv));
      bread(12'h10, r); chk({tag, " R3 cur"}, 64'(r), 64'(e.cv));
      bwrite(12'h1C, 32'h1);
    end
    bread(12'h20, r);
    chk({tag, " R6 empty after pops"}, 64'(r[15:8]), 64'd0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int s = 0; s < NS; s++) en_m[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    bread(12'h00, r); chk("R1 ctrl", 64'(r), 0);
    bread(12'h20, r); chk("R1 status", 64'(r), 0);
    chk("R1 irq", 64'(irq), 0);

    // R9 enable masks
    en_m[0] = 32'hFFFF_FFFF; en_m[1] = 32'h0000_00F0; en_m[2] = 32'h8000_0001;
    for (int s = 0; s < NS; s++) bwrite(12'(64 + 32*s), en_m[s]);
    bread(12'h80, r); chk("R9 mask readback", 64'(r), 64'h8000_0001);

    // R9 global enable off
    toggle(96'h8);
    bread(12'h20, r); chk("R9 no record when disabled", 64'(r[15:8]), 0);

    bwrite(12'h00, 32'h1); gen_on = 1'b1;
    tick(5);
    // R2 R3 R4
    toggle(96'h81);
    drain("R2 single");
    // R3 disabled line masked from difference
    toggle({32'h0, 32'h0000_1010, 32'h0});
    drain("R3 mixed mask");

    // R5 simultaneous slices
    tick(1000);
    toggle({32'h8000_0000, 32'h0000_0020, 32'h0000_0002});
    bread(12'h20, r); chk("R10 count three", 64'(r[15:8]), 3);

    // R8
    bwrite(12'h00, 32'h0000_0303);
    #1 chk("R8 irq at threshold", 64'(irq), 1);
    bwrite(12'h00, 32'h0000_0403);
    #1 chk("R8 irq below threshold", 64'(irq), 0);
    bwrite(12'h00, 32'h0000_0301);
    #1 chk("R8 irq masked", 64'(irq), 0);
    drain("R5 multi slice");

    // R6 pop on empty and empty reads
    bwrite(12'h1C, 32'h1);
    bread(12'h20, r); chk("R6 empty pop", 64'(r), 0);
    bread(12'h10, r); chk("R6 empty record reads zero", 64'(r), 0);
    tick(7);
    toggle(96'h4);
    drain("R6 after empty pop");

    // R7 overflow
    for (int k = 0; k < 10; k++) toggle(96'(1) << (8 + k));
    bread(12'h20, r);
    chk("R7 full count", 64'(r[15:8]), 8);
    chk("R7 overflow set", 64'(r[0]), 1);
    drain("R7 kept records");
    bread(12'h20, r); chk("R7 overflow sticky", 64'(r[0]), 1);
    bwrite(12'h1C, 32'h2);
    bread(12'h20, r); chk("R7 overflow cleared", 64'(r), 0);

    // R9 line with clear mask bit
    toggle({32'h0000_0020, 64'h0});
    bread(12'h20, r); chk("R9 masked line ignored", 64'(r[15:8]), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule